// File: doc/BRIEF.md
# Fully Associative Translation Cache with Least-Recently-Used Replacement

This block holds a small set of virtual-to-physical page translations, each with three attribute flags: writable, user-accessible and global. Any entry may hold any page. A lookup compares the requested virtual page against every valid entry in the same cycle. It returns a hit flag, the physical page and the attribute flags. The requester may ask for the hit to count as a use, which refreshes that entry's recency.

New translations come through an insert port. An insert takes the lowest-numbered free entry. When no entry is free, it displaces the entry that was used least recently. Recency is kept as a stamp per entry, taken from a 32-bit sequence counter. A maintenance port offers three invalidations: drop everything, drop every entry not marked global, and drop the single entry for a given page. The entry count is a parameter, and a count of zero stops elaboration.

Top module: `xlate_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid. Every lookup misses, and on a miss `lk_ppn` and `lk_attr` read zero.
- R2: A lookup is combinational. In the same cycle it reports `lk_hit`, plus the physical page and attributes of the valid entry whose page matches. Attribute bit 2 is writable, bit 1 is user and bit 0 is global.
- R3: An insert of an absent page makes that page hit from the next cycle. While a free entry exists, the insert displaces no valid entry.
- R4: When every entry is valid, an insert of an absent page replaces the entry with the smallest recency stamp. On equal stamps the lowest index is replaced. A 32-bit counter advances by one on every accepted new insert and every recency-updating hit, and the entry being written or refreshed takes the counter's value.
- R5: A hit with `lk_touch` high refreshes that entry's stamp. A lookup with `lk_touch` low leaves recency unchanged.
- R6: An insert of a page that is already present changes nothing. The old physical page and attributes remain, and recency does not move.
- R7: Maintenance code 1 (flush all) invalidates every entry.
- R8: Maintenance code 2 (flush non-global) invalidates only the entries whose global bit is clear.
- R9: Maintenance code 3 (demap) invalidates the entry matching `mt_vpn` and nothing else; a page that is not present leaves the cache unchanged. Code 0 is a no-op.
- R10: Only one operation takes effect per cycle. When `mt_valid` is high, any insert and any recency update in that cycle are dropped. When `ins_valid` is high, any recency update in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page being looked up |
| lk_touch | input | 1 | Count a hit in this cycle as a use |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | PPN_W | Physical page of the matching entry, zero on a miss |
| lk_attr | output | 3 | {writable, user, global} of the match, zero on a miss |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Virtual page to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_attr | input | 3 | {writable, user, global} to insert |
| mt_valid | input | 1 | Maintenance request |
| mt_op | input | 2 | 0 no-op, 1 flush all, 2 flush non-global, 3 demap |
| mt_vpn | input | VPN_W | Page to demap |

## Verification
A wrong recency stamp or a wrong counter is invisible at the lookup port until the cache is full. It shows up on the first insert after that, as the wrong page going missing, so the bench fills the cache and then follows a precise eviction order. A wrong valid bit or a wrong global flag shows up one cycle after the maintenance command, on the next lookup of the affected page. The bench therefore probes both the dropped pages and the retained pages after each flush and demap. An insert that wrongly overwrites a duplicate changes `lk_ppn` on the very next lookup. It also shifts the next eviction, and the bench checks both.

// File: rtl/xlate_cache_pkg.sv
// Package: shared types for the translation cache.
// Assumes attribute packing {writable, user, global}, MSB first.
package xlate_cache_pkg;

    typedef struct packed {
        logic writable;
        logic user;
        logic global;
    } attr_t;

    typedef enum logic [1:0] {
        OP_NOP         = 2'd0,
        OP_FLUSH_ALL   = 2'd1,
        OP_FLUSH_LOCAL = 2'd2,
        OP_DEMAP       = 2'd3
    } maint_op_t;

endpackage

// File: rtl/xlate_match.sv
// Module: xlate_match
// Compares one key against every stored page tag in parallel and returns
// a hit vector, an any-hit flag and the encoded index of the hit.
// Assumes at most one valid entry carries a given tag (inserts never duplicate).
module xlate_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          any_hit,
    output logic [IDX_W-1:0]              hit_idx
);

    // One comparator per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && (tags[i] == key);
    end

    assign any_hit = |hit_vec;

    // OR-encode the one-hot hit vector into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlate_victim.sv
// Module: xlate_victim
// Picks the slot an insert writes: the lowest free slot if any, otherwise
// the slot with the smallest stamp, searching from slot 0 with strict
// less-than so that ties go to the lower index.
// Assumes stamps of invalid slots are never consulted.
module xlate_victim #(
    parameter int ENTRIES = 8,
    parameter int STAMP_W = 32,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][STAMP_W-1:0] stamps,
    output logic [IDX_W-1:0]                slot
);

    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;

    // Lowest-index free slot: scan downwards so the last write wins.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Oldest stamp: start from slot 0, compare against slots 1..N-1.
    always_comb begin
        lru_idx = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (stamps[i] < stamps[lru_idx]) lru_idx = IDX_W'(i);
        end
    end

    assign slot = have_free ? free_idx : lru_idx;

endmodule

// File: rtl/xlate_cache.sv
// Module: xlate_cache (top)
// Fully associative translation cache with per-entry recency stamps.
// Combinational lookup; one state-changing operation per clock with
// priority maintenance > insert > recency update.
// Assumes ENTRIES >= 1 and that the 32-bit stamp counter does not wrap.
module xlate_cache
    import xlate_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int STAMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_touch,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [2:0]       lk_attr,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [2:0]       ins_attr,
    input  logic             mt_valid,
    input  logic [1:0]       mt_op,
    input  logic [VPN_W-1:0] mt_vpn
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Reject an empty cache at elaboration.
    if (ENTRIES < 1) begin : g_bad_size
        $fatal(1, "xlate_cache: ENTRIES must be at least 1");
    end

    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]   tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
    attr_t [ENTRIES-1:0]             attr_q;
    logic [ENTRIES-1:0][STAMP_W-1:0] stamp_q;
    logic [STAMP_W-1:0]              seq_q;
    logic [ENTRIES-1:0]              glob_vec;

    logic [ENTRIES-1:0] lk_vec, dm_hit, ins_vec;
    logic               ins_dup, dm_any;
    logic [IDX_W-1:0]   lk_idx, dm_idx, ins_idx, victim;
    maint_op_t          op;

    assign op = maint_op_t'(mt_op);

    // Global flags as a flat vector for the selective flush.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
        assign glob_vec[i] = attr_q[i].global;
    end

    xlate_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .valid(valid_q), .tags(tag_q), .key(lk_vpn),
        .hit_vec(lk_vec), .any_hit(lk_hit), .hit_idx(lk_idx)
    );

    xlate_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_dm_match (
        .valid(valid_q), .tags(tag_q), .key(mt_vpn),
        .hit_vec(dm_hit), .any_hit(dm_any), .hit_idx(dm_idx)
    );

    xlate_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_ins_match (
        .valid(valid_q), .tags(tag_q), .key(ins_vpn),
        .hit_vec(ins_vec), .any_hit(ins_dup), .hit_idx(ins_idx)
    );

    xlate_victim #(.ENTRIES(ENTRIES), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_victim (
        .valid(valid_q), .stamps(stamp_q), .slot(victim)
    );

    // Lookup result; zero on a miss.
    assign lk_ppn  = lk_hit ? ppn_q[lk_idx] : '0;
    assign lk_attr = lk_hit ? attr_q[lk_idx] : 3'b000;

    // Entry state and recency counter update, one operation per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            seq_q   <= '0;
        end else if (mt_valid) begin
            case (op)
                OP_FLUSH_ALL:   valid_q <= '0;
                OP_FLUSH_LOCAL: valid_q <= valid_q & glob_vec;
                OP_DEMAP:       valid_q <= valid_q & ~dm_hit;
                default:        ;
            endcase
        end else if (ins_valid) begin
            if (!ins_dup) begin
                valid_q[victim] <= 1'b1;
                tag_q[victim]   <= ins_vpn;
                ppn_q[victim]   <= ins_ppn;
                attr_q[victim]  <= attr_t'(ins_attr);
                stamp_q[victim] <= seq_q;
                seq_q           <= seq_q + 1'b1;
            end
        end else if (lk_touch && lk_hit) begin
            stamp_q[lk_idx] <= seq_q;
            seq_q           <= seq_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_cache_chk.sv
// Module: xlate_cache_chk
// Property checker bound into xlate_cache; observes entry state and the
// recency counter against the commands seen at the ports.
// Assumes the synchronous active-low reset of the host block.
module xlate_cache_chk #(
    parameter int ENTRIES = 8,
    parameter int STAMP_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ENTRIES-1:0] valid,
    input logic [ENTRIES-1:0] glob,
    input logic [STAMP_W-1:0] seq,
    input logic [ENTRIES-1:0] dm_hit,
    input logic               ins_dup,
    input logic               mt_valid,
    input logic [1:0]         mt_op,
    input logic               ins_valid,
    input logic               lk_touch,
    input logic               lk_hit
);

    logic after_rst;

    // Remembers that the previous cycle was in reset.
    always_ff @(posedge clk) after_rst <= !rst_n;

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (valid == '0));

    p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid != '0));

    p_touch_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_valid && !ins_valid && lk_touch && lk_hit)
        |=> (seq == $past(seq) + {{(STAMP_W-1){1'b0}}, 1'b1}));

    p_dup_insert_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_valid && ins_valid && ins_dup) |=> ($stable(valid) && $stable(seq)));

    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && mt_op == 2'd1) |=> (valid == '0));

    p_flush_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && mt_op == 2'd2) |=> (valid == $past(valid & glob)));

    p_demap_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && mt_op == 2'd3) |=> (valid == $past(valid & ~dm_hit)));

    p_maint_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && mt_op == 2'd0) |=> ($stable(valid) && $stable(seq)));

endmodule

bind xlate_cache xlate_cache_chk #(.ENTRIES(ENTRIES), .STAMP_W(STAMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .glob(glob_vec), .seq(seq_q),
    .dm_hit(dm_hit), .ins_dup(ins_dup), .mt_valid(mt_valid), .mt_op(mt_op),
    .ins_valid(ins_valid), .lk_touch(lk_touch), .lk_hit(lk_hit)
);

// File: tb/xlate_cache_test.sv
module xlate_cache_test;

    localparam int N  = 4;
    localparam int VW = 20;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_touch = 1'b0;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic [2:0]    lk_attr;
    logic          ins_valid = 1'b0;
    logic [VW-1:0] ins_vpn = '0;
    logic [PW-1:0] ins_ppn = '0;
    logic [2:0]    ins_attr = '0;
    logic          mt_valid = 1'b0;
    logic [1:0]    mt_op = '0;
    logic [VW-1:0] mt_vpn = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xlate_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .STAMP_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_touch(lk_touch),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .ins_attr(ins_attr), .mt_valid(mt_valid), .mt_op(mt_op), .mt_vpn(mt_vpn)
    );

    // kind: 0 probe only, 1 insert, 2 maintenance
    typedef struct packed {
        logic [1:0]    kind;
        logic [1:0]    mop;
        logic [VW-1:0] vpn;
        logic [PW-1:0] ppn;
        logic [2:0]    attr;
        logic          touch;
        logic [VW-1:0] qvpn;
        logic          ehit;
        logic [PW-1:0] eppn;
        logic [2:0]    eattr;
        logic [3:0]    req;
    } step_t;

    localparam int NSTEP = 18;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd1, 2'd0, 20'h10, 20'hA10, 3'b100, 1'b0, 20'h10, 1'b1, 20'hA10, 3'b100, 4'd2}, // R2
        '{2'd1, 2'd0, 20'h11, 20'hA11, 3'b010, 1'b0, 20'h11, 1'b1, 20'hA11, 3'b010, 4'd2}, // R2
        '{2'd1, 2'd0, 20'h12, 20'hA12, 3'b001, 1'b0, 20'h12, 1'b1, 20'hA12, 3'b001, 4'd3}, // R3
        '{2'd1, 2'd0, 20'h13, 20'hA13, 3'b111, 1'b0, 20'h13, 1'b1, 20'hA13, 3'b111, 4'd3}, // R3
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b1, 20'h10, 1'b1, 20'hA10, 3'b100, 4'd5}, // R5 touch 0x10
        '{2'd1, 2'd0, 20'h14, 20'hA14, 3'b000, 1'b0, 20'h11, 1'b0, 20'h0,   3'b000, 4'd4}, // R4 evict 0x11
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b0, 20'h10, 1'b1, 20'hA10, 3'b100, 4'd5}, // R5 touched kept
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b0, 20'h12, 1'b1, 20'hA12, 3'b001, 4'd5}, // R5 plain probe
        '{2'd1, 2'd0, 20'h15, 20'hA15, 3'b100, 1'b0, 20'h12, 1'b0, 20'h0,   3'b000, 4'd5}, // R5 no refresh
        '{2'd1, 2'd0, 20'h13, 20'hBBB, 3'b000, 1'b0, 20'h13, 1'b1, 20'hA13, 3'b111, 4'd6}, // R6 duplicate
        '{2'd1, 2'd0, 20'h16, 20'hA16, 3'b001, 1'b0, 20'h13, 1'b0, 20'h0,   3'b000, 4'd6}, // R6 recency kept
        '{2'd2, 2'd3, 20'h14, 20'h0,   3'b000, 1'b0, 20'h14, 1'b0, 20'h0,   3'b000, 4'd9}, // R9 demap
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b0, 20'h10, 1'b1, 20'hA10, 3'b100, 4'd9}, // R9 others kept
        '{2'd2, 2'd3, 20'h77, 20'h0,   3'b000, 1'b0, 20'h15, 1'b1, 20'hA15, 3'b100, 4'd9}, // R9 absent page
        '{2'd2, 2'd2, 20'h0,  20'h0,   3'b000, 1'b0, 20'h16, 1'b1, 20'hA16, 3'b001, 4'd8}, // R8 global kept
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b0, 20'h10, 1'b0, 20'h0,   3'b000, 4'd8}, // R8 dropped
        '{2'd0, 2'd0, 20'h0,  20'h0,   3'b000, 1'b0, 20'h15, 1'b0, 20'h0,   3'b000, 4'd8}, // R8 dropped
        '{2'd2, 2'd1, 20'h0,  20'h0,   3'b000, 1'b0, 20'h16, 1'b0, 20'h0,   3'b000, 4'd7}  // R7 flush all
    };

    task automatic check(input int req, input logic eh, input logic [PW-1:0] ep,
                         input logic [2:0] ea);
        checks++;
        if ({lk_hit, lk_ppn, lk_attr} !== {eh, ep, ea}) begin
            errors++;
            $display("FAIL R%0d vpn=%h got hit=%b ppn=%h attr=%b expected hit=%b ppn=%h attr=%b",
                     req, lk_vpn, lk_hit, lk_ppn, lk_attr, eh, ep, ea);
        end
    endtask

    task automatic probe(input int req, input logic [VW-1:0] v, input logic eh,
                         input logic [PW-1:0] ep, input logic [2:0] ea);
        lk_vpn = v;
        #1;
        check(req, eh, ep, ea);
    endtask

    task automatic do_ins(input logic [VW-1:0] v, input logic [PW-1:0] p,
                          input logic [2:0] a);
        @(negedge clk);
        lk_touch = 1'b0;
        ins_valid = 1'b1; ins_vpn = v; ins_ppn = p; ins_attr = a;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_mt(input logic [1:0] op, input logic [VW-1:0] v);
        @(negedge clk);
        lk_touch = 1'b0;
        mt_valid = 1'b1; mt_op = op; mt_vpn = v;
        @(negedge clk);
        mt_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        probe(1, 20'h10, 1'b0, '0, 3'b000);
        probe(1, 20'h0,  1'b0, '0, 3'b000);

        // Table walk
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            lk_touch = 1'b0;
            if (STEPS[i].kind == 2'd1) begin
                ins_valid = 1'b1; ins_vpn = STEPS[i].vpn;
                ins_ppn = STEPS[i].ppn; ins_attr = STEPS[i].attr;
            end else if (STEPS[i].kind == 2'd2) begin
                mt_valid = 1'b1; mt_op = STEPS[i].mop; mt_vpn = STEPS[i].vpn;
            end
            if (STEPS[i].kind != 2'd0) begin
                @(negedge clk);
                ins_valid = 1'b0;
                mt_valid = 1'b0;
            end
            lk_vpn = STEPS[i].qvpn;
            lk_touch = STEPS[i].touch;
            #1;
            check(int'(STEPS[i].req), STEPS[i].ehit, STEPS[i].eppn, STEPS[i].eattr);
        end
        @(negedge clk);
        lk_touch = 1'b0;

        // R3: fill, free one middle slot, refill without displacing anything
        for (int i = 0; i < 4; i++) do_ins(VW'(32 + i), PW'(12'hB20 + i), 3'b000);
        for (int i = 0; i < 4; i++) probe(3, VW'(32 + i), 1'b1, PW'(12'hB20 + i), 3'b000);
        do_mt(2'd3, 20'h21);
        probe(9, 20'h21, 1'b0, '0, 3'b000);
        do_ins(20'h24, 20'hB24, 3'b010);
        probe(3, 20'h20, 1'b1, 20'hB20, 3'b000);
        probe(3, 20'h22, 1'b1, 20'hB22, 3'b000);
        probe(3, 20'h23, 1'b1, 20'hB23, 3'b000);
        probe(3, 20'h24, 1'b1, 20'hB24, 3'b010);

        // R10: maintenance wins over an insert in the same cycle
        @(negedge clk);
        mt_valid = 1'b1; mt_op = 2'd1;
        ins_valid = 1'b1; ins_vpn = 20'h30; ins_ppn = 20'hC30; ins_attr = 3'b000;
        @(negedge clk);
        mt_valid = 1'b0; ins_valid = 1'b0;
        probe(10, 20'h30, 1'b0, '0, 3'b000);
        probe(7,  20'h20, 1'b0, '0, 3'b000);

        // R10: insert wins over a recency update in the same cycle
        for (int i = 0; i < 4; i++) do_ins(VW'(64 + i), PW'(12'hD40 + i), 3'b000);
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = 20'h44; ins_ppn = 20'hD44; ins_attr = 3'b100;
        lk_vpn = 20'h40; lk_touch = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0; lk_touch = 1'b0;
        probe(10, 20'h40, 1'b0, '0, 3'b000);
        probe(4,  20'h44, 1'b1, 20'hD44, 3'b100);

        // R9: code 0 is a no-op and still blocks a same-cycle insert (R10)
        @(negedge clk);
        mt_valid = 1'b1; mt_op = 2'd0;
        ins_valid = 1'b1; ins_vpn = 20'h45; ins_ppn = 20'hD45; ins_attr = 3'b000;
        @(negedge clk);
        mt_valid = 1'b0; ins_valid = 1'b0;
        probe(10, 20'h45, 1'b0, '0, 3'b000);
        probe(9,  20'h41, 1'b1, 20'hD41, 3'b000);

        // R1: reset in mid-run clears every entry
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(1, 20'h41, 1'b0, '0, 3'b000);
        probe(1, 20'h44, 1'b0, '0, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule